// File: doc/BRIEF.md
# Path Trace String Monitor

This block watches the path trace byte that arrives once per frame and checks the repeating string it carries against an expected string held in a small internal table. Two string formats can be chosen with one mode input. The short format is a 16-byte string that is aligned on its framing byte and protected by a CRC-7. The long format is a 64-byte string with no framing, which may arrive at any rotation.

When a completed string disagrees with the table, the block sets a sticky mismatch flag. In the short format, a string whose CRC-7 fails sets a sticky CRC flag instead, and that string is not used for the mismatch decision. Software loads the table through a plain write port and clears both flags with a single read-clear strobe. In the short format, software must load an expected string whose framing byte already holds the correct CRC-7. The block itself does not check the table.

Top module: `trc_monitor`

## Requirements
- R1: After reset, both `mism_o` and `crc_err_o` are 0.
- R2: In short mode (`mode_short`=1), a string starts at a valid byte with bit 7 set. The string is that framing byte followed by 15 valid bytes with bit 7 clear, and it is judged when its 16th byte is taken. Valid bytes with bit 7 clear that arrive while no string is open are ignored.
- R3: The CRC-7 uses generator x^7+x^3+1 and starts from zero. It is computed MSB first over the 16 bytes of a string, with the framing byte's bits 6:0 taken as zero. If the result differs from the framing byte's bits 6:0, `crc_err_o` is set one cycle later. `crc_err_o` is never set in long mode.
- R4: A string that fails its CRC-7 never sets `mism_o`, even if its content differs from the table.
- R5: In short mode, a string that passes its CRC-7 sets `mism_o` if any of its bytes differs from table entries 0 to 15 in order, with the framing byte compared to entry 0. A string that matches sets nothing.
- R6: In short mode, a byte with bit 7 set that arrives before a string is complete abandons the partial string and opens a new one.
- R7: In long mode, valid bytes are grouped in windows of 64. A window sets `mism_o` when it equals no rotation of table entries 0 to 63. A window that equals some rotation sets nothing.
- R8: Both flags are sticky and are cleared by `rd_clr`. When a flag-setting event and `rd_clr` fall in the same cycle, the flag ends up set.
- R9: A write (`wr_en`) stores `wr_data` at logical entry `wr_addr`. A write, or any change of `mode_short`, abandons the string or window in progress, and a valid byte in that cycle is ignored.
- R10: Bytes are taken only in cycles where `trc_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_byte | input | 8 | Received trace byte |
| trc_vld | input | 1 | `trc_byte` is valid this cycle |
| mode_short | input | 1 | 1: 16-byte CRC-framed string; 0: 64-byte string |
| wr_en | input | 1 | Write strobe for the expected table |
| wr_addr | input | 6 | Logical table entry to write |
| wr_data | input | 8 | Value to write |
| rd_clr | input | 1 | Clears both sticky flags |
| mism_o | output | 1 | Sticky trace mismatch flag |
| crc_err_o | output | 1 | Sticky CRC-7 error flag |

## Verification
Two events can land on the same clock edge. One is the evaluation of a completed string or window. The other is either a read-clear or a write to the table.

The bench raises `rd_clr` in the very cycle that carries the 16th byte of a string with a bad CRC, and it expects `crc_err_o` to stay at 1. It also places a table write, together with a valid byte, in the middle of a string whose remaining bytes would otherwise complete a mismatching string, and it expects both flags to remain 0.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int              TRC_CRC_W    = 7;
    localparam logic [6:0]      TRC_CRC_POLY = 7'h09;  // x^7 + x^3 + 1
    typedef logic [7:0]         trc_byte_t;
endpackage

// File: rtl/trc_crc7_step.sv
module trc_crc7_step
    import trc_pkg::*;
#(
    parameter int              W    = TRC_CRC_W,
    parameter logic [W-1:0]    POLY = TRC_CRC_POLY
) (
    input  logic [W-1:0] crc_i,
    input  trc_byte_t    data_i,
    output logic [W-1:0] crc_o
);
    always_comb begin
        logic [W-1:0] c;
        logic         fb;
        c = crc_i;
        for (int b = 7; b >= 0; b--) begin
            fb = c[W-1] ^ data_i[b];
            c  = {c[W-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        crc_o = c;
    end
endmodule

// File: rtl/trc_rot_match.sv
module trc_rot_match
    import trc_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [N-1:0][7:0] exp_i,
    input  trc_byte_t         byte_i,
    output logic [N-1:0]      hit_o
);
    for (genvar k = 0; k < N; k++) begin : g_cmp
        assign hit_o[k] = (exp_i[k] == byte_i);
    end
endmodule

// File: rtl/trc_monitor.sv
module trc_monitor
    import trc_pkg::*;
#(
    parameter int LONG_LEN  = 64,   // power of two
    parameter int SHORT_LEN = 16    // power of two, not above LONG_LEN
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  trc_byte,
    input  logic                        trc_vld,
    input  logic                        mode_short,
    input  logic                        wr_en,
    input  logic [$clog2(LONG_LEN)-1:0] wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic                        rd_clr,
    output logic                        mism_o,
    output logic                        crc_err_o
);
    localparam int AW = $clog2(LONG_LEN);
    localparam int PW = $clog2(SHORT_LEN);
    localparam int CW = TRC_CRC_W;

    typedef struct packed {
        logic [LONG_LEN-1:0][7:0] exp;    // physical j holds logical (j+rot)
        logic [AW-1:0]            rot;
        logic [LONG_LEN-1:0]      alive;  // rotations still consistent
        logic [AW-1:0]            wcnt;
        logic                     locked;
        logic [PW-1:0]            pos;
        logic [CW-1:0]            crc;
        logic [CW-1:0]            rxcrc;
        logic                     diff;
        logic                     mode;
        logic                     mism;
        logic                     crcerr;
    } st_t;

    st_t st_q, st_d;

    logic            frm;
    logic [CW-1:0]   crc_in, crc_nx;
    trc_byte_t       crc_data;
    logic [AW-1:0]   rd_idx, wr_idx;
    trc_byte_t       exp_byte;
    logic [LONG_LEN-1:0] hit;

    assign frm      = trc_byte[7];
    assign crc_in   = frm ? '0 : st_q.crc;
    assign crc_data = frm ? 8'h80 : trc_byte;
    assign rd_idx   = (frm ? '0 : AW'(st_q.pos)) - st_q.rot;
    assign wr_idx   = wr_addr - st_q.rot;
    assign exp_byte = st_q.exp[rd_idx];

    trc_crc7_step #(.W(CW), .POLY(TRC_CRC_POLY)) u_crc (
        .crc_i (crc_in),
        .data_i(crc_data),
        .crc_o (crc_nx)
    );

    trc_rot_match #(.N(LONG_LEN)) u_match (
        .exp_i (st_q.exp),
        .byte_i(trc_byte),
        .hit_o (hit)
    );

    always_comb begin
        logic set_m, set_c, restart, diff_nx;
        logic [LONG_LEN-1:0] alive_nx;
        st_d     = st_q;
        set_m    = 1'b0;
        set_c    = 1'b0;
        diff_nx  = 1'b0;
        alive_nx = st_q.alive & hit;
        restart  = wr_en || (mode_short != st_q.mode);
        st_d.mode = mode_short;
        if (wr_en) st_d.exp[wr_idx] = wr_data;
        if (restart) begin
            st_d.locked = 1'b0;
            st_d.alive  = '1;
            st_d.wcnt   = '0;
        end else if (trc_vld) begin
            if (mode_short) begin
                if (frm) begin
                    st_d.locked = 1'b1;
                    st_d.pos    = PW'(1);
                    st_d.crc    = crc_nx;
                    st_d.rxcrc  = trc_byte[CW-1:0];
                    st_d.diff   = (trc_byte != exp_byte);
                end else if (st_q.locked) begin
                    diff_nx   = st_q.diff | (trc_byte != exp_byte);
                    st_d.crc  = crc_nx;
                    st_d.diff = diff_nx;
                    if (st_q.pos == PW'(SHORT_LEN - 1)) begin
                        st_d.locked = 1'b0;
                        if (crc_nx != st_q.rxcrc) set_c = 1'b1;
                        else if (diff_nx)         set_m = 1'b1;
                    end else begin
                        st_d.pos = st_q.pos + PW'(1);
                    end
                end
            end else begin
                st_d.exp = {st_q.exp[0], st_q.exp[LONG_LEN-1:1]};
                st_d.rot = st_q.rot + AW'(1);
                if (st_q.wcnt == AW'(LONG_LEN - 1)) begin
                    st_d.wcnt  = '0;
                    st_d.alive = '1;
                    if (alive_nx == '0) set_m = 1'b1;
                end else begin
                    st_d.wcnt  = st_q.wcnt + AW'(1);
                    st_d.alive = alive_nx;
                end
            end
        end
        st_d.mism   = (st_q.mism   & ~rd_clr) | set_m;
        st_d.crcerr = (st_q.crcerr & ~rd_clr) | set_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.alive <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mism_o    = st_q.mism;
    assign crc_err_o = st_q.crcerr;
endmodule

// File: rtl/trc_monitor_chk.sv
module trc_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic trc_vld,
    input logic wr_en,
    input logic mode_short,
    input logic rd_clr,
    input logic mism_o,
    input logic crc_err_o
);
    // R10 / R9: mismatch only rises after a byte taken in a non-write cycle
    p_mism_needs_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mism_o) |-> $past(trc_vld && !wr_en));

    // R3: CRC flag only rises after a short-mode byte
    p_crc_short_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err_o) |-> $past(mode_short && trc_vld));

    // R4: a CRC failure never raises mismatch in the same evaluation
    p_crc_masks_mism_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err_o) |-> !$rose(mism_o));

    // R8: flags fall only through the read-clear strobe
    p_mism_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mism_o) |-> $past(rd_clr));

    p_crc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_err_o) |-> $past(rd_clr));
endmodule

bind trc_monitor trc_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trc_vld   (trc_vld),
    .wr_en     (wr_en),
    .mode_short(mode_short),
    .rd_clr    (rd_clr),
    .mism_o    (mism_o),
    .crc_err_o (crc_err_o)
);

// File: tb/trc_monitor_test.sv
module trc_monitor_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] trc_byte = '0;
    logic       trc_vld = 1'b0;
    logic       mode_short = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_clr = 1'b0;
    logic       mism_o, crc_err_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp16 [16];
    logic [7:0] exp64 [64];
    logic [7:0] s16 [16];
    logic [7:0] s64 [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    trc_monitor uut (
        .clk(clk), .rst_n(rst_n), .trc_byte(trc_byte), .trc_vld(trc_vld),
        .mode_short(mode_short), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_clr(rd_clr), .mism_o(mism_o), .crc_err_o(crc_err_o)
    );

    function automatic logic [6:0] crc_of(input logic [7:0] s [16]);
        logic [6:0] c = '0;
        logic [7:0] b;
        logic fb;
        for (int i = 0; i < 16; i++) begin
            b = (i == 0) ? 8'h80 : s[i];
            for (int j = 7; j >= 0; j--) begin
                fb = c[6] ^ b[j];
                c  = {c[5:0], 1'b0};
                if (fb) c = c ^ 7'h09;
            end
        end
        return c;
    endfunction

    task automatic check(input string req, input logic act, input logic expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] b, input logic we,
                         input logic [5:0] a, input logic [7:0] d, input logic c);
        @(negedge clk);
        trc_vld = v; trc_byte = b; wr_en = we; wr_addr = a; wr_data = d; rd_clr = c;
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 1'b0, 6'd0, 8'h00, 1'b0);
    endtask

    task automatic clr();
        drive(1'b0, 8'h00, 1'b0, 6'd0, 8'h00, 1'b1);
        idle();
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        drive(1'b0, 8'h00, 1'b1, a, d, 1'b0);
    endtask

    task automatic send16(input logic clr_last);
        for (int i = 0; i < 16; i++)
            drive(1'b1, s16[i], 1'b0, 6'd0, 8'h00, clr_last && (i == 15));
        idle();
    endtask

    task automatic send64();
        for (int i = 0; i < 64; i++) drive(1'b1, s64[i], 1'b0, 6'd0, 8'h00, 1'b0);
        idle();
    endtask

    task automatic load16();
        for (int i = 1; i < 16; i++) exp16[i] = 8'($urandom) & 8'h7f;
        exp16[0] = {1'b1, crc_of(exp16)};
        for (int i = 0; i < 16; i++) wr(6'(i), exp16[i]);
        idle();
    endtask

    // corrupt one content byte (bits 6:0 only); optionally refresh the CRC
    task automatic corrupt16(input bit fix_crc);
        int idx;
        idx = 1 + int'($urandom % 15);
        s16[idx] = s16[idx] ^ 8'(1 + ($urandom % 127));
        if (fix_crc) s16[0] = {1'b1, crc_of(s16)};
    endtask

    task automatic expect2(input string req, input logic m, input logic c);
        check({req, " mism"}, mism_o, m);
        check({req, " crc"}, crc_err_o, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        expect2("R1 reset", 1'b0, 1'b0);

        // ---------- short mode ----------
        load16();
        // R2: unframed junk before lock is ignored, then a good string
        for (int i = 0; i < 5; i++) drive(1'b1, 8'($urandom) & 8'h7f, 1'b0, 6'd0, 8'h00, 1'b0);
        s16 = exp16;
        send16(1'b0);
        expect2("R2 R5 good string", 1'b0, 1'b0);

        s16 = exp16; corrupt16(1'b1); send16(1'b0);
        expect2("R5 content differs", 1'b1, 1'b0);
        clr();
        expect2("R8 cleared", 1'b0, 1'b0);

        s16 = exp16; corrupt16(1'b0); send16(1'b0);
        expect2("R3 R4 crc error masks", 1'b0, 1'b1);
        clr();

        // R6: partial bad string abandoned by a new framing byte
        s16 = exp16; corrupt16(1'b1);
        for (int i = 0; i < 9; i++) drive(1'b1, s16[i], 1'b0, 6'd0, 8'h00, 1'b0);
        s16 = exp16; send16(1'b0);
        expect2("R6 reframe", 1'b0, 1'b0);

        // R8: clear in the same cycle as a CRC event
        s16 = exp16; corrupt16(1'b0); send16(1'b1);
        check("R8 set beats clear", crc_err_o, 1'b1);
        clr();

        // R9: write mid-string with a valid byte in the write cycle
        s16 = exp16; corrupt16(1'b1);
        for (int i = 0; i < 14; i++) drive(1'b1, s16[i], 1'b0, 6'd0, 8'h00, 1'b0);
        drive(1'b1, s16[14], 1'b1, 6'd5, exp16[5], 1'b0);
        drive(1'b1, s16[15], 1'b0, 6'd0, 8'h00, 1'b0);
        idle();
        expect2("R9 write abandons string", 1'b0, 1'b0);

        // R10: junk on idle cycles with trc_vld low
        s16 = exp16; corrupt16(1'b1);
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, s16[i], 1'b0, 6'd0, 8'h00, 1'b0);
            drive(1'b0, 8'h80 | 8'($urandom), 1'b0, 6'd0, 8'h00, 1'b0);
        end
        idle();
        expect2("R10 gaps ignored", 1'b1, 1'b0);
        clr();

        // random short-mode strings
        for (int t = 0; t < 12; t++) begin
            int kind;
            kind = int'($urandom % 3);
            s16 = exp16;
            if (kind != 0) corrupt16(kind == 1);
            send16(1'b0);
            expect2(kind == 0 ? "R5 rnd good" : (kind == 1 ? "R5 rnd diff" : "R4 rnd crc"),
                    kind == 1, kind == 2);
            clr();
        end

        // ---------- long mode ----------
        @(negedge clk); mode_short = 1'b0;
        idle();
        for (int i = 0; i < 64; i++) begin
            exp64[i] = 8'($urandom);
            wr(6'(i), exp64[i]);
        end
        idle();
        for (int t = 0; t < 12; t++) begin
            int r, bad;
            r   = int'($urandom % 64);
            bad = (t < 2) ? t : int'($urandom % 2);
            for (int i = 0; i < 64; i++) s64[i] = exp64[(i + r) % 64];
            if (bad != 0) begin
                int p;
                p = int'($urandom % 64);
                s64[p] = s64[p] ^ 8'(1 + ($urandom % 255));
            end
            send64();
            expect2(bad != 0 ? "R7 R3 rotation corrupted" : "R7 R3 rotation ok",
                    bad != 0, 1'b0);
            clr();
        end

        // leave a partial window so the table is rotated, then return to short mode
        for (int i = 0; i < 5; i++) drive(1'b1, 8'($urandom), 1'b0, 6'd0, 8'h00, 1'b0);
        @(negedge clk); mode_short = 1'b1;
        idle();
        load16();
        s16 = exp16; send16(1'b0);
        expect2("R9 logical write after rotation", 1'b0, 1'b0);
        s16 = exp16; corrupt16(1'b1); send16(1'b0);
        expect2("R5 after rotation", 1'b1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule